// File: doc/BRIEF.md
# Interleaved Round-Loop AES-128 Encryptor

This block encrypts 128-bit blocks with AES-128 and holds only one round of logic. That round is split into four register stages: byte substitution, row rotation, column mixing, and round-key addition. The stages sit in a closed loop, so a block passes around the loop ten times before its ciphertext is ready.

The loop always holds four slots, one per stage register. Each slot carries its own block state, its own current round key, its own round number and its own tag. The round keys are expanded on the fly: each slot derives its next round key from its previous one once per trip around the loop. A single block therefore uses each stage only one cycle in four. Up to four independent blocks can share the loop, and four blocks offered on consecutive cycles keep every stage busy.

Plaintext enters through a valid/ready port together with its key and a tag. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high. The source may hold `in_valid` high while `in_ready` is low, and must then keep the block, key and tag unchanged. `in_ready` depends only on the block's internal state, never on `in_valid`. The output port has no back-pressure. Each finished block is shown for exactly one cycle with `out_valid` high, and the sink must take it in that cycle.

Top module: `rlc_cipher_loop`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: `in_ready` is low in exactly those cycles when the slot about to re-enter the first stage holds a block that has finished between one and nine rounds. A block accepted on edge k makes `in_ready` low after edges k+3, k+7, …, k+35.
- R3: `out_block` equals AES-128 encryption of the accepted `in_block` under the accepted `in_key`. Byte 0 of a 128-bit value is bits 127:120, and bytes are taken column by column. For example, plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: A block accepted on rising edge k appears with `out_valid` high in the cycle after edge k+39, which is a fixed latency of 40 edges. `out_valid` is low in every cycle where no block is due.
- R5: `out_tag` equals the tag captured with the same block.
- R6: Four blocks offered back to back on an idle loop are accepted on four consecutive edges and leave on four consecutive cycles.
- R7: In a cycle where `out_valid` is high, `in_ready` is also high, so the slot being freed can take a new block on that same edge.
- R8: Blocks leave in the order they were accepted, whatever the gaps between them at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a block |
| in_ready | output | 1 | A slot is free at the loop entry |
| in_block | input | 128 | Plaintext |
| in_key | input | 128 | Cipher key for this block |
| in_tag | input | TAG_W | Caller's label for this block |
| out_valid | output | 1 | Ciphertext present, one-cycle pulse |
| out_block | output | 128 | Ciphertext |
| out_tag | output | TAG_W | Label of the block on `out_block` |

## Verification
The loop is tested with four input patterns:

- **Lone blocks on an idle loop.** This pins the 40-edge latency and the standard known answers without any interleaving.
- **Exactly four blocks back to back.** This shows full-rate filling and consecutive exits.
- **A long burst with `in_valid` held high.** This forces `in_ready` to drop. It separates a correct slot-occupancy rule from one that lets a new block overwrite a block still in flight, and it shows whether a freed slot is refilled in the very cycle it empties.
- **Blocks with irregular gaps and a different key per block.** This checks that keys and tags stay attached to their own slot when several unrelated blocks are in flight.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  // Doubling in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // Inverse as a^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  // Round constant for round r (r >= 1)
  function automatic logic [7:0] rcon(input int r);
    logic [7:0] c;
    c = 8'h01;
    for (int i = 1; i < 16; i++) begin
      if (i < r) c = gf_dbl(c);
    end
    return c;
  endfunction

endpackage

// File: rtl/rlc_sub_layer.sv
module rlc_sub_layer #(
  parameter int NBYTES = 16
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  import rlc_pkg::*;

  for (genvar g = 0; g < NBYTES; g++) begin : g_sb
    assign dout[8*g +: 8] = sbox(din[8*g +: 8]);
  end
endmodule

// File: rtl/rlc_mix_layer.sv
module rlc_mix_layer #(
  parameter int NCOLS = 4
) (
  input  logic [32*NCOLS-1:0] din,
  input  logic                bypass,
  output logic [32*NCOLS-1:0] dout
);
  import rlc_pkg::*;

  logic [32*NCOLS-1:0] mixed;

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    logic [7:0] a0, a1, a2, a3;
    assign a0 = din[32*c+24 +: 8];
    assign a1 = din[32*c+16 +: 8];
    assign a2 = din[32*c+8  +: 8];
    assign a3 = din[32*c    +: 8];
    assign mixed[32*c+24 +: 8] = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
    assign mixed[32*c+16 +: 8] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
    assign mixed[32*c+8  +: 8] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
    assign mixed[32*c    +: 8] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
  end

  assign dout = bypass ? din : mixed;
endmodule

// File: rtl/rlc_key_step.sv
module rlc_key_step #(
  parameter int RND_W = 4
) (
  input  logic [127:0]     key_prev,
  input  logic [RND_W-1:0] rnd,
  output logic [127:0]     key_next
);
  import rlc_pkg::*;

  logic [31:0] w0, w1, w2, w3, t, n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = key_prev;
  assign t  = {sbox(w3[23:16]) ^ rcon(int'(rnd)), sbox(w3[15:8]),
               sbox(w3[7:0]), sbox(w3[31:24])};
  assign n0 = w0 ^ t;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign key_next = {n0, n1, n2, n3};
endmodule

// File: rtl/rlc_cipher_loop.sv
module rlc_cipher_loop #(
  parameter int TAG_W      = 8,
  parameter int NUM_ROUNDS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [127:0]     in_block,
  input  logic [127:0]     in_key,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [127:0]     out_block,
  output logic [TAG_W-1:0] out_tag
);
  localparam int RND_W = $clog2(NUM_ROUNDS + 1);
  localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS);

  typedef struct packed {
    logic             vld;
    logic [RND_W-1:0] rnd;
    logic [TAG_W-1:0] tag;
    logic [127:0]     st;
    logic [127:0]     rk;
  } slot_t;

  slot_t s_in, p1, p2, p3, p4;
  logic  finish, loop_back, take;
  logic [127:0] sub_out, shf_out, mix_out, key_out;

  assign finish    = p4.vld && (p4.rnd == LAST);
  assign loop_back = p4.vld && (p4.rnd != LAST);
  assign in_ready  = !loop_back;
  assign take      = in_valid && in_ready;

  // Entry mux: returning slot has priority; a freed slot may take a new block
  always_comb begin
    s_in = '0;
    if (loop_back) begin
      s_in     = p4;
      s_in.rnd = p4.rnd + RND_W'(1);
    end else if (take) begin
      s_in.vld = 1'b1;
      s_in.rnd = RND_W'(1);
      s_in.tag = in_tag;
      s_in.st  = in_block ^ in_key;
      s_in.rk  = in_key;
    end
  end

  rlc_sub_layer #(.NBYTES(16)) u_sub (.din(s_in.st), .dout(sub_out));

  // Row rotation: byte (r,c) takes byte (r,(c+r)%4); byte 0 sits at bits 127:120
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        shf_out[127-8*(r+4*c) -: 8] = p1.st[127-8*(r+4*((c+r)%4)) -: 8];
      end
    end
  end

  rlc_mix_layer #(.NCOLS(4)) u_mix (
    .din(p2.st), .bypass(p2.rnd == LAST), .dout(mix_out));

  rlc_key_step #(.RND_W(RND_W)) u_key (
    .key_prev(p2.rk), .rnd(p2.rnd), .key_next(key_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0;
      p2 <= '0;
      p3 <= '0;
      p4 <= '0;
    end else begin
      p1    <= s_in;
      p1.st <= sub_out;
      p2    <= p1;
      p2.st <= shf_out;
      p3    <= p2;
      p3.st <= mix_out;
      p3.rk <= key_out;
      p4    <= p3;
      p4.st <= p3.st ^ p3.rk;
    end
  end

  assign out_valid = finish;
  assign out_block = p4.st;
  assign out_tag   = p4.tag;

  AST_ENTRY_FIRST_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (p1.vld && p1.rnd == RND_W'(1) && p1.tag == $past(in_tag))); // R2

  AST_ROUND_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (p4.vld && p4.rnd != LAST) |=> (p1.vld && p1.rnd == $past(p4.rnd) + RND_W'(1))); // R4

  AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    p2.vld |=> (p3.vld && p3.tag == $past(p2.tag))); // R5

  AST_FREE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R7

  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    p3.vld |-> (p3.rnd >= RND_W'(1) && p3.rnd <= LAST)); // R4

  AST_QUIET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !(p4.vld && p4.rnd != LAST)) |=> !p1.vld); // R2
endmodule

// File: tb/rlc_cipher_loop_tb.sv
`timescale 1ns/1ps
module rlc_cipher_loop_tb_top;
  localparam int TAG_W = 8;
  localparam int NITEM = 30;
  localparam int HIST  = 2048;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [127:0]     in_block = '0;
  logic [127:0]     in_key = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             out_valid;
  logic [127:0]     out_block;
  logic [TAG_W-1:0] out_tag;

  always #2.5 clk = ~clk;

  rlc_cipher_loop #(.TAG_W(TAG_W), .NUM_ROUNDS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .in_key(in_key), .in_tag(in_tag),
    .out_valid(out_valid), .out_block(out_block), .out_tag(out_tag));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] sbt [256];

  function automatic logic [7:0] xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = xt(x);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] sb_calc(input int v);
    logic [7:0] inv = 0;
    logic [7:0] s;
    logic [7:0] cst = 8'h63;
    for (int y = 1; y < 256; y++) if (gm(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ cst[i];
    return s;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
    logic [7:0] s[16];
    logic [7:0] k[16];
    logic [7:0] t[16];
    logic [7:0] rc = 8'h01;
    logic [7:0] q0, q1, q2, q3;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      k[i] = key[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ k[i];
    end
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) s[i] = sbt[s[i]];
      for (int col = 0; col < 4; col++)
        for (int row = 0; row < 4; row++)
          t[row+4*col] = s[row+4*((col+row)%4)];
      for (int col = 0; col < 4; col++) begin
        q0 = t[4*col]; q1 = t[4*col+1]; q2 = t[4*col+2]; q3 = t[4*col+3];
        if (rd != 10) begin
          s[4*col]   = gm(2,q0) ^ gm(3,q1) ^ q2 ^ q3;
          s[4*col+1] = q0 ^ gm(2,q1) ^ gm(3,q2) ^ q3;
          s[4*col+2] = q0 ^ q1 ^ gm(2,q2) ^ gm(3,q3);
          s[4*col+3] = gm(3,q0) ^ q1 ^ q2 ^ gm(2,q3);
        end else begin
          s[4*col] = q0; s[4*col+1] = q1; s[4*col+2] = q2; s[4*col+3] = q3;
        end
      end
      q0 = sbt[k[13]] ^ rc; q1 = sbt[k[14]]; q2 = sbt[k[15]]; q3 = sbt[k[12]];
      k[0] ^= q0; k[1] ^= q1; k[2] ^= q2; k[3] ^= q3;
      for (int i = 4; i < 16; i++) k[i] ^= k[i-4];
      rc = xt(rc);
      for (int i = 0; i < 16; i++) s[i] ^= k[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // ---------------- stimulus items and expectation history ----------------
  logic [127:0] it_pt [NITEM];
  logic [127:0] it_key[NITEM];
  int           it_gap[NITEM];
  int           it_acc[NITEM];

  bit           acc_at [HIST];
  bit           exp_v  [HIST];
  logic [127:0] exp_ct [HIST];
  logic [7:0]   exp_tag[HIST];
  int           out_seq = 0;
  int           exp_seq[HIST];

  localparam logic [127:0] PT_A = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] KY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] CT_A = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] PT_B = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] KY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] CT_B = 128'h3925841d02dc09fbdc118597196a0b32;

  bit ready_exp;
  int idx;
  int waitcnt;
  int tail;
  logic [15:0] lfsr;

  initial begin
    for (int v = 0; v < 256; v++) sbt[v] = sb_calc(v);
    for (int h = 0; h < HIST; h++) begin
      acc_at[h] = 0; exp_v[h] = 0; exp_ct[h] = '0; exp_tag[h] = '0; exp_seq[h] = 0;
    end

    // R3: the reference itself reproduces the standard answers
    chk(ref_enc(PT_A, KY_A) == CT_A, "R3", "reference known answer A", ref_enc(PT_A, KY_A), CT_A);
    chk(ref_enc(PT_B, KY_B) == CT_B, "R3", "reference known answer B", ref_enc(PT_B, KY_B), CT_B);

    lfsr = 16'hace1;
    for (int i = 0; i < NITEM; i++) begin
      it_pt[i]  = {4{32'h9e3779b9 * (i + 3)}} ^ {i[7:0], 120'h0};
      it_key[i] = {32'h1234 * (i + 7), 32'hc0ffee00 + i, 32'h55aa55aa ^ i, 32'h0f0f0f0f * i};
      it_acc[i] = -1;
      if (i >= 18) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        it_gap[i] = lfsr % 6;
      end else begin
        it_gap[i] = 0;
      end
    end
    it_pt[0] = PT_A; it_key[0] = KY_A; it_gap[0] = 2;
    it_pt[1] = PT_B; it_key[1] = KY_B; it_gap[1] = 45;
    it_gap[2] = 45;   // four back to back: items 2..5
    it_gap[6] = 45;   // long burst: items 6..17
    it_gap[18] = 45;  // irregular gaps from here

    // reset phase, R1
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", 128'(in_ready), 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 128'(in_ready), 128'd1);

    idx = 0;
    waitcnt = it_gap[0];
    tail = 0;
    while (tail < 50) begin
      @(negedge clk);
      if (cyc >= 1900) begin
        chk(1'b0, "R4", "watchdog expired", 128'(cyc), 128'd1900);
        break;
      end
      // expected ready: a block accepted on edge k blocks entry after k+3..k+35 step 4
      ready_exp = 1'b1;
      for (int j = 3; j <= 35; j += 4)
        if (cyc - j >= 0 && acc_at[cyc - j]) ready_exp = 1'b0;
      chk(in_ready == ready_exp, "R2", "in_ready", 128'(in_ready), 128'(ready_exp));
      chk(out_valid == exp_v[cyc], "R4", "out_valid timing", 128'(out_valid), 128'(exp_v[cyc]));
      if (out_valid && exp_v[cyc]) begin
        chk(out_block == exp_ct[cyc], "R3", "ciphertext", out_block, exp_ct[cyc]);
        chk(out_tag == exp_tag[cyc], "R5", "tag", 128'(out_tag), 128'(exp_tag[cyc]));
        chk(exp_seq[cyc] == out_seq, "R8", "exit order", 128'(exp_seq[cyc]), 128'(out_seq));
        chk(in_ready == 1'b1, "R7", "slot free on exit", 128'(in_ready), 128'd1);
        if (out_tag == 8'd0)
          chk(out_block == CT_A, "R3", "known answer A from design", out_block, CT_A);
        if (out_tag == 8'd1)
          chk(out_block == CT_B, "R3", "known answer B from design", out_block, CT_B);
        out_seq++;
      end
      // drive next offer
      if (idx < NITEM) begin
        if (waitcnt > 0) begin
          in_valid = 1'b0;
          waitcnt--;
        end else begin
          in_valid = 1'b1;
          in_block = it_pt[idx];
          in_key   = it_key[idx];
          in_tag   = 8'(idx);
          if (in_ready) begin
            acc_at[cyc + 1]       = 1'b1;
            exp_v[cyc + 40]       = 1'b1;
            exp_ct[cyc + 40]      = ref_enc(it_pt[idx], it_key[idx]);
            exp_tag[cyc + 40]     = 8'(idx);
            exp_seq[cyc + 40]     = idx;
            it_acc[idx]           = cyc + 1;
            idx++;
            if (idx < NITEM) waitcnt = it_gap[idx];
          end
        end
      end else begin
        in_valid = 1'b0;
        tail++;
      end
    end

    // R6: items 2..5 taken on consecutive edges (exit timing covered by R4 checks)
    for (int i = 3; i <= 5; i++)
      chk(it_acc[i] == it_acc[i-1] + 1, "R6", "back-to-back acceptance",
          128'(it_acc[i]), 128'(it_acc[i-1] + 1));
    chk(out_seq == NITEM, "R8", "all blocks delivered", 128'(out_seq), 128'(NITEM));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule